// File: doc/BRIEF.md
# Add/Multiply Calculator with Decimal Readout

This block is a purely combinational two-operation arithmetic unit. It takes two five-bit unsigned operands and an operation select. It zero-extends both operands to eight bits and returns either their sum or a restricted product. The product uses only the two low bits of the second operand.

The eight-bit adder is a carry-select structure built from four-bit ripple sections. The low nibble is computed once. The high nibble is computed twice, once for each possible incoming carry, and the low carry picks the right copy. The multiplier forms two gated partial products and sums them on a second copy of the same adder.

Three decimal readouts show operand A, operand B and the low five bits of the result. Each readout drives two active-low seven-segment digits: tens and ones.

Top module: `addmul_calc`

## Requirements
- R1: When `op_mul` is 0, `result` equals (A + B) mod 256, where A and B are the zero-extended operands.
- R2: When `op_mul` is 1, `result` equals (A × (B mod 4)) mod 256. Bits 4 to 2 of `opnd_b` have no effect on `result` in this mode.
- R3: For a readout value v in 0..31, the tens digit is 0 for v < 10, 1 for 10..19, 2 for 20..29 and 3 for 30..31.
- R4: The ones digit of a readout is v minus ten times its tens digit.
- R5: Segment words are active-low with bit 6 = g, bit 5 = f, bit 4 = e, bit 3 = d, bit 2 = c, bit 1 = b and bit 0 = a. The digit codes are 0→0x40, 1→0x79, 2→0x24, 3→0x30, 4→0x19, 5→0x12, 6→0x02, 7→0x78, 8→0x00 and 9→0x10.
- R6: The result readout shows the low five bits of `result`. For example, a sum of 40 shows as "08".
- R7: A tens digit of 0 is still drawn, as pattern 0x40.
- R8: The operand A and operand B readouts depend only on their own operand and do not change with `op_mul`.
- R9: Every output is a pure function of the current inputs. No state is held and no latch is inferred, so outputs are valid in the same evaluation as an input change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 5 | First operand, unsigned |
| opnd_b | input | 5 | Second operand, unsigned |
| op_mul | input | 1 | 0 selects add, 1 selects multiply |
| result | output | 8 | Arithmetic result |
| seg_a_tens | output | 7 | Operand A tens digit, active-low segments |
| seg_a_ones | output | 7 | Operand A ones digit |
| seg_b_tens | output | 7 | Operand B tens digit |
| seg_b_ones | output | 7 | Operand B ones digit |
| seg_r_tens | output | 7 | Result tens digit, from result[4:0] |
| seg_r_ones | output | 7 | Result ones digit |

## Verification
The bound checker re-evaluates several relations on every input change:
- the add and multiply results against an arithmetic model;
- that every segment word is one of the ten legal digit patterns;
- the forced leading zero;
- the operand readouts against their own operands.

Other behaviour shows up only in the bench's full sweep of all 2048 operand and select combinations. This covers the exact tens and ones split at every boundary (9/10, 19/20, 29/30), the wrap of results above 31 in the result readout, and the independence of the product from the upper bits of B.

// File: rtl/addmul_calc.sv
module addmul_calc #(
  parameter int OPW  = 5,
  parameter int DPW  = 8,
  parameter int SEGW = 7
) (
  input  logic [OPW-1:0]  opnd_a,
  input  logic [OPW-1:0]  opnd_b,
  input  logic            op_mul,
  output logic [DPW-1:0]  result,
  output logic [SEGW-1:0] seg_a_tens,
  output logic [SEGW-1:0] seg_a_ones,
  output logic [SEGW-1:0] seg_b_tens,
  output logic [SEGW-1:0] seg_b_ones,
  output logic [SEGW-1:0] seg_r_tens,
  output logic [SEGW-1:0] seg_r_ones
);
  localparam int NW    = DPW / 2;
  localparam int NDISP = 3;

  function automatic logic [NW:0] ripple(input logic [NW-1:0] x, input logic [NW-1:0] y,
                                          input logic ci);
    logic c;
    logic [NW-1:0] s;
    c = ci;
    for (int i = 0; i < NW; i++) begin
      s[i] = x[i] ^ y[i] ^ c;
      c    = (x[i] & y[i]) | (c & (x[i] ^ y[i]));
    end
    return {c, s};
  endfunction

  function automatic logic [DPW:0] csel_add(input logic [DPW-1:0] x, input logic [DPW-1:0] y,
                                             input logic ci);
    logic [NW:0] lo, hi0, hi1, hi;
    lo  = ripple(x[NW-1:0], y[NW-1:0], ci);
    hi0 = ripple(x[DPW-1:NW], y[DPW-1:NW], 1'b0);
    hi1 = ripple(x[DPW-1:NW], y[DPW-1:NW], 1'b1);
    hi  = lo[NW] ? hi1 : hi0;
    return {hi, lo[NW-1:0]};
  endfunction

  function automatic logic [7:0] to_digits(input logic [4:0] v);
    logic [1:0] t;
    logic [4:0] sub;
    if (v >= 5'd30)      begin t = 2'd3; sub = 5'd30; end
    else if (v >= 5'd20) begin t = 2'd2; sub = 5'd20; end
    else if (v >= 5'd10) begin t = 2'd1; sub = 5'd10; end
    else                 begin t = 2'd0; sub = 5'd0;  end
    return {2'b00, t, 4'(v - sub)};
  endfunction

  function automatic logic [SEGW-1:0] seg_code(input logic [3:0] d);
    case (d)
      4'd0: return 7'h40;
      4'd1: return 7'h79;
      4'd2: return 7'h24;
      4'd3: return 7'h30;
      4'd4: return 7'h19;
      4'd5: return 7'h12;
      4'd6: return 7'h02;
      4'd7: return 7'h78;
      4'd8: return 7'h00;
      4'd9: return 7'h10;
      default: return 7'h7f;
    endcase
  endfunction

  logic [DPW-1:0] a_w, b_w, pp0, pp1, sum_v, prod_v;
  logic           unused_carry, unused_mcarry;

  assign a_w = DPW'(opnd_a);
  assign b_w = DPW'(opnd_b);
  assign pp0 = a_w & {DPW{b_w[0]}};
  assign pp1 = (a_w & {DPW{b_w[1]}}) << 1;

  assign {unused_carry,  sum_v}  = csel_add(a_w, b_w, 1'b0);
  assign {unused_mcarry, prod_v} = csel_add(pp0, pp1, 1'b0);
  assign result = op_mul ? prod_v : sum_v;

  logic [4:0]      disp_val [NDISP];
  logic [SEGW-1:0] disp_t   [NDISP];
  logic [SEGW-1:0] disp_o   [NDISP];

  assign disp_val[0] = 5'(opnd_a);
  assign disp_val[1] = 5'(opnd_b);
  assign disp_val[2] = result[4:0];

  for (genvar g = 0; g < NDISP; g++) begin : g_disp
    logic [7:0] dg;
    assign dg        = to_digits(disp_val[g]);
    assign disp_t[g] = seg_code(dg[7:4]);
    assign disp_o[g] = seg_code(dg[3:0]);
  end

  assign seg_a_tens = disp_t[0];
  assign seg_a_ones = disp_o[0];
  assign seg_b_tens = disp_t[1];
  assign seg_b_ones = disp_o[1];
  assign seg_r_tens = disp_t[2];
  assign seg_r_ones = disp_o[2];
endmodule

module addmul_calc_chk #(
  parameter int OPW  = 5,
  parameter int DPW  = 8,
  parameter int SEGW = 7
) (
  input logic [OPW-1:0]  opnd_a,
  input logic [OPW-1:0]  opnd_b,
  input logic            op_mul,
  input logic [DPW-1:0]  result,
  input logic [SEGW-1:0] seg_a_tens,
  input logic [SEGW-1:0] seg_a_ones,
  input logic [SEGW-1:0] seg_b_tens,
  input logic [SEGW-1:0] seg_b_ones,
  input logic [SEGW-1:0] seg_r_tens,
  input logic [SEGW-1:0] seg_r_ones
);
  function automatic logic legal(input logic [SEGW-1:0] s);
    return s == 7'h40 || s == 7'h79 || s == 7'h24 || s == 7'h30 || s == 7'h19 ||
           s == 7'h12 || s == 7'h02 || s == 7'h78 || s == 7'h00 || s == 7'h10;
  endfunction

  always_comb begin
    if (!op_mul)
      assert_sum_R1: assert (result == DPW'(32'(opnd_a) + 32'(opnd_b)));
    if (op_mul)
      assert_product_R2: assert (result == DPW'(32'(opnd_a) * 32'(opnd_b % 4)));
    assert_legal_segments_R5: assert (legal(seg_a_tens) && legal(seg_a_ones) &&
                                      legal(seg_b_tens) && legal(seg_b_ones) &&
                                      legal(seg_r_tens) && legal(seg_r_ones));
    if (opnd_a < 10)
      assert_leading_zero_R7: assert (seg_a_tens == 7'h40);
    if (opnd_b == 31)
      assert_operand_only_R8: assert (seg_b_tens == 7'h30 && seg_b_ones == 7'h79);
    if (result[4:0] < 10)
      assert_result_low_bits_R6: assert (seg_r_tens == 7'h40);
  end
endmodule

bind addmul_calc addmul_calc_chk #(.OPW(OPW), .DPW(DPW), .SEGW(SEGW)) chk_i (.*);

// File: tb/addmul_calc_tb.sv
module addmul_calc_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] opnd_a = '0, opnd_b = '0;
  logic op_mul = 1'b0;
  logic [7:0] result;
  logic [6:0] seg_a_tens, seg_a_ones, seg_b_tens, seg_b_ones, seg_r_tens, seg_r_ones;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    logic [4:0] a, b;
    logic       m;
    logic [7:0] res;
    logic [6:0] s [6];
  } exp_t;

  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  addmul_calc dut_i (.*);

  function automatic logic [6:0] pat(input int d);
    case (d)
      0: return 7'h40; 1: return 7'h79; 2: return 7'h24; 3: return 7'h30; 4: return 7'h19;
      5: return 7'h12; 6: return 7'h02; 7: return 7'h78; 8: return 7'h00; default: return 7'h10;
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp,
                       input exp_t e);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s a=%0d b=%0d op=%0d actual=%h expected=%h", req, e.a, e.b, e.m, act, exp);
    end
  endtask

  task automatic drive(input int a, input int b, input int m);
    exp_t e;
    int rv, rd;
    @(posedge clk);
    opnd_a = 5'(a); opnd_b = 5'(b); op_mul = m[0];
    e.a = 5'(a); e.b = 5'(b); e.m = m[0];
    rv = m[0] ? (a * (b % 4)) % 256 : (a + b) % 256;
    e.res = 8'(rv);
    rd = rv % 32;
    e.s[0] = pat(a / 10);  e.s[1] = pat(a % 10);
    e.s[2] = pat(b / 10);  e.s[3] = pat(b % 10);
    e.s[4] = pat(rd / 10); e.s[5] = pat(rd % 10);
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (rst_n && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      // same-cycle validity of every output: R9
      check(e.m ? "R2 R9 result" : "R1 R9 result", result, e.res, e);
      // operand readouts: R3 tens, R4 ones, R5 codes, R7 leading zero, R8 op independence
      check("R3 R5 R7 R8 seg_a_tens", {1'b0, seg_a_tens}, {1'b0, e.s[0]}, e);
      check("R4 R5 R8 seg_a_ones", {1'b0, seg_a_ones}, {1'b0, e.s[1]}, e);
      check("R3 R5 R8 seg_b_tens", {1'b0, seg_b_tens}, {1'b0, e.s[2]}, e);
      check("R4 R5 R8 seg_b_ones", {1'b0, seg_b_ones}, {1'b0, e.s[3]}, e);
      check("R6 seg_r_tens", {1'b0, seg_r_tens}, {1'b0, e.s[4]}, e);
      check("R6 seg_r_ones", {1'b0, seg_r_ones}, {1'b0, e.s[5]}, e);
    end
  end

  initial begin
    exp_t z;
    repeat (3) @(posedge clk);
    @(negedge clk);
    z.a = 0; z.b = 0; z.m = 0;
    // reset-state check: all-zero inputs give zero and "00" readouts (R7)
    check("R1 R7 reset result", result, 8'h00, z);
    check("R7 reset seg_r_tens", {1'b0, seg_r_tens}, 8'h40, z);
    rst_n = 1'b1;
    for (int m = 0; m < 2; m++)
      for (int a = 0; a < 32; a++)
        for (int b = 0; b < 32; b++)
          drive(a, b, m);
    // boundary sums that wrap the result readout (R6): 31+9=40 -> "08"
    drive(31, 9, 0);
    drive(31, 31, 0);
    // R2: high bits of B ignored in multiply
    drive(17, 28, 1);
    drive(31, 31, 1);
    while (q.size() > 0) @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R9 actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule